// File: doc/BRIEF.md
# Joypad Matrix and Interrupt Controller

This block combines a button-matrix read register with a small interrupt flag and enable pair. Eight active-low button lines arrive as two groups of four. Two select bits, written by the CPU, choose which group appears on the low nibble of the matrix register. They can also choose both groups together, which gives the bitwise AND of the groups, or neither, which gives all ones. The button lines are sampled on every clock. Any displayed line that goes from 1 to 0 raises the joypad request. The cause can be a button press or a change of the select bits.

Five request sources share a flag register. The joypad is one of them, and the timer, the serial port and the others arrive as single-cycle pulses. The flags are masked by an enable register and reduced to one CPU interrupt line. The CPU reaches the three registers through a 2-bit register index with a write strobe and a combinational read bus. Vectoring and acknowledge are handled elsewhere.

Top module: `joypad_irq_regs`

## Requirements
- R1: After reset, the matrix register reads 0xCF, the flag register reads 0xE0, the enable register reads 0x00 and `cpu_irq` is low.
- R2: Index 0 is the matrix register. A write stores only data bits 5:4 as the select pair. Bits 7:6 always read as 1, and the written low nibble has no effect on what is read.
- R3: Select 2'b10 shows `pad_state[3:0]` in bits 3:0, and select 2'b01 shows `pad_state[7:4]`. The nibble is sampled on each clock edge, so it is current one edge after a write or a state change.
- R4: Select 2'b00 shows `pad_state[3:0] & pad_state[7:4]`, and select 2'b11 shows 4'hF.
- R5: A 1-to-0 change on any bit of the displayed nibble sets flag bit 4 at that edge. The change may come from `pad_state` or from a select write. A 0-to-1 change sets nothing.
- R6: Index 1 is the flag register. A write stores data bits 4:0, and bits 7:5 always read as 1.
- R7: A pulse on `hw_req[i]` sets flag bit i at that edge (bit 2 timer, bit 3 serial, bit 4 joypad and other). When it meets a CPU flag write in the same cycle, the pulse is ORed in after the write.
- R8: A flag read returns the flag value that was held before the most recent clock edge, which is one edge behind.
- R9: `cpu_irq` is high exactly when (flags AND enable) is nonzero in bits 4:0. It follows flag writes, enable writes and hardware sets one edge later, and enable bits 7:5 have no effect on it.
- R10: Index 2 is the enable register, a full 8-bit read/write register that reads back at once. Index 3 reads 0xFF, and writes to it are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_addr | input | 2 | Register index: 0 matrix, 1 flags, 2 enable, 3 unused |
| cpu_we | input | 1 | Write strobe for the indexed register |
| cpu_wdata | input | 8 | Write data |
| cpu_rdata | output | 8 | Combinational read data for the indexed register |
| pad_state | input | 8 | Active-low buttons: group A in 3:0, group B in 7:4 |
| hw_req | input | 5 | Single-cycle request pulses, one per flag bit |
| cpu_irq | output | 1 | Interrupt line to the CPU |

## Verification
Two events can land on the same flag edge: a CPU write to the flag register and a hardware request pulse. The bench provokes this by driving a flag write of 0x01 together with a serial pulse on bit 3 in the same cycle. It then judges that the flags settle to 0xE9, so the write did not wipe out the request. A second overlap occurs when a select write itself causes a nibble bit to fall. The bench moves from select 2'b11 to 2'b10 with a low button present and expects flag bit 4 to be set without any change on `pad_state`.

// File: rtl/joy_irq_pkg.sv
// Package: shared widths, register indices and bit positions for the
// joypad matrix and interrupt controller.
package joy_irq_pkg;
    localparam int DATA_W  = 8;
    localparam int GRP_W   = 4;
    localparam int SRC_N   = 5;
    localparam int JOY_BIT = 4;

    typedef enum logic [1:0] {
        REG_PAD  = 2'd0,
        REG_FLAG = 2'd1,
        REG_ENAB = 2'd2,
        REG_NONE = 2'd3
    } reg_sel_e;
endpackage

// File: rtl/pad_matrix.sv
// Module: pad_matrix
// Holds the active-low select pair and a sampled nibble of the button
// matrix. Raises fall_o (combinational) when any displayed bit goes 1->0
// at the coming edge. Assumes pad_state is synchronous to clk.
module pad_matrix #(
    parameter int GRP_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               sel_we,
    input  logic [1:0]         sel_wdata,
    input  logic [2*GRP_W-1:0] pad_state,
    output logic [1:0]         sel_q,
    output logic [GRP_W-1:0]   nib_q,
    output logic               fall_o
);
    logic [1:0]       sel_next;
    logic [GRP_W-1:0] nib_next;
    logic [GRP_W-1:0] grp_a;
    logic [GRP_W-1:0] grp_b;

    assign grp_a = pad_state[GRP_W-1:0];
    assign grp_b = pad_state[2*GRP_W-1:GRP_W];

    // Next select pair and the nibble it shows.
    always_comb begin
        sel_next = sel_we ? sel_wdata : sel_q;
        case (sel_next)
            2'b10:   nib_next = grp_a;
            2'b01:   nib_next = grp_b;
            2'b00:   nib_next = grp_a & grp_b;
            default: nib_next = '1;
        endcase
    end

    // Falling edge on any displayed line.
    assign fall_o = |(nib_q & ~nib_next);

    // Register the select pair and the sampled nibble.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sel_q <= 2'b00;
            nib_q <= '1;
        end else begin
            sel_q <= sel_next;
            nib_q <= nib_next;
        end
    end

    // Select only changes on a write.
    p_sel_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel_we |=> $stable(sel_q));
    // Neither group selected shows all ones.
    p_none_sel_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (sel_q == 2'b11) |-> (nib_q == '1));
endmodule

// File: rtl/irq_flags.sv
// Module: irq_flags
// Flag and enable registers with a one-edge-delayed flag copy for reads
// and a registered interrupt line. Hardware sets are ORed after a CPU
// flag write so that no request is lost.
module irq_flags #(
    parameter int SRC_N  = 5,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flag_we,
    input  logic              enab_we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [SRC_N-1:0]  src_set,
    output logic [SRC_N-1:0]  flag_q,
    output logic [SRC_N-1:0]  flag_prev_q,
    output logic [DATA_W-1:0] enab_q,
    output logic              irq_o
);
    logic [SRC_N-1:0]  flag_next;
    logic [DATA_W-1:0] enab_next;

    // Write first, then merge hardware requests.
    always_comb begin
        flag_next = (flag_we ? wdata[SRC_N-1:0] : flag_q) | src_set;
        enab_next = enab_we ? wdata : enab_q;
    end

    // Register flags, delayed copy, enables and the interrupt line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q      <= '0;
            flag_prev_q <= '0;
            enab_q      <= '0;
            irq_o       <= 1'b0;
        end else begin
            flag_q      <= flag_next;
            flag_prev_q <= flag_q;
            enab_q      <= enab_next;
            irq_o       <= |(flag_next & enab_next[SRC_N-1:0]);
        end
    end

    // A requested source is set at the next edge.
    p_hw_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (src_set != '0) |=> ((flag_q & $past(src_set)) == $past(src_set)));
    // The line agrees with the masked flags.
    p_irq_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o == |(flag_q & enab_q[SRC_N-1:0]));
endmodule

// File: rtl/joypad_irq_regs.sv
// Module: joypad_irq_regs (top)
// Decodes the CPU register port onto the matrix and the interrupt
// registers, muxes read data, and routes the joypad fall event to its
// flag bit. Assumes all inputs are synchronous to clk.
module joypad_irq_regs
    import joy_irq_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cpu_addr,
    input  logic              cpu_we,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic [DATA_W-1:0] cpu_rdata,
    input  logic [2*GRP_W-1:0] pad_state,
    input  logic [SRC_N-1:0]  hw_req,
    output logic              cpu_irq
);
    localparam int PAD_SEL_LO = GRP_W;
    localparam int FLAG_PAD_W = DATA_W - SRC_N;

    logic [1:0]       sel_q;
    logic [GRP_W-1:0] nib_q;
    logic             pad_fall;
    logic [SRC_N-1:0] src_set;
    logic [SRC_N-1:0] flag_q;
    logic [SRC_N-1:0] flag_prev_q;
    logic [DATA_W-1:0] enab_q;
    logic             we_pad, we_flag, we_enab;

    // Write decode per register index.
    assign we_pad  = cpu_we && (cpu_addr == REG_PAD);
    assign we_flag = cpu_we && (cpu_addr == REG_FLAG);
    assign we_enab = cpu_we && (cpu_addr == REG_ENAB);

    // Joypad fall event drives its own flag bit.
    assign src_set = hw_req | (SRC_N'(pad_fall) << JOY_BIT);

    pad_matrix #(.GRP_W(GRP_W)) u_pad (
        .clk       (clk),
        .rst_n     (rst_n),
        .sel_we    (we_pad),
        .sel_wdata (cpu_wdata[PAD_SEL_LO+1:PAD_SEL_LO]),
        .pad_state (pad_state),
        .sel_q     (sel_q),
        .nib_q     (nib_q),
        .fall_o    (pad_fall)
    );

    irq_flags #(.SRC_N(SRC_N), .DATA_W(DATA_W)) u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .flag_we     (we_flag),
        .enab_we     (we_enab),
        .wdata       (cpu_wdata),
        .src_set     (src_set),
        .flag_q      (flag_q),
        .flag_prev_q (flag_prev_q),
        .enab_q      (enab_q),
        .irq_o       (cpu_irq)
    );

    // Read data mux; flags return the delayed copy.
    always_comb begin
        case (cpu_addr)
            REG_PAD:  cpu_rdata = {2'b11, sel_q, nib_q};
            REG_FLAG: cpu_rdata = {{FLAG_PAD_W{1'b1}}, flag_prev_q};
            REG_ENAB: cpu_rdata = enab_q;
            default:  cpu_rdata = '1;
        endcase
    end

    // Matrix register top bits always read as ones.
    p_pad_top_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == REG_PAD) |-> (cpu_rdata[7:6] == 2'b11));
    // Flag register upper bits always read as ones.
    p_flag_top_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_addr == REG_FLAG) |-> (cpu_rdata[7:5] == 3'b111));
endmodule

// File: tb/joypad_irq_regs_bench.sv
module joypad_irq_regs_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cpu_addr = 2'd0;
    logic       cpu_we = 1'b0;
    logic [7:0] cpu_wdata = 8'h00;
    logic [7:0] cpu_rdata;
    logic [7:0] pad_state = 8'hFF;
    logic [4:0] hw_req = 5'd0;
    logic       cpu_irq;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    joypad_irq_regs u_joypad_irq_regs (
        .clk(clk), .rst_n(rst_n), .cpu_addr(cpu_addr), .cpu_we(cpu_we),
        .cpu_wdata(cpu_wdata), .cpu_rdata(cpu_rdata), .pad_state(pad_state),
        .hw_req(hw_req), .cpu_irq(cpu_irq)
    );

    task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
        checks++;
        if (got !== exp) begin
            failures++;
            $display("FAIL %s actual=%02h expected=%02h", req, got, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_addr = a; cpu_wdata = d; cpu_we = 1'b1;
        @(negedge clk);
        cpu_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        cpu_addr = a;
        #1;
        d = cpu_rdata;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic test_reset();
        logic [7:0] v;
        idle(1);
        rd(2'd0, v); check("R1 pad", v, 8'hCF);
        rd(2'd1, v); check("R1 flags", v, 8'hE0);
        rd(2'd2, v); check("R1 enable", v, 8'h00);
        check("R1 irq", {7'd0, cpu_irq}, 8'h00);
    endtask

    task automatic test_pad_write();
        logic [7:0] v;
        wr(2'd0, 8'h25);
        rd(2'd0, v); check("R2 only select stored", v, 8'hEF);
        wr(2'd1, 8'h00); idle(1);
    endtask

    task automatic test_groups();
        logic [7:0] v;
        pad_state = 8'hA5; idle(1);
        rd(2'd0, v); check("R3 group A", v, 8'hE5);
        wr(2'd0, 8'h10);
        rd(2'd0, v); check("R3 group B", v, 8'hDA);
        wr(2'd0, 8'h00);
        rd(2'd0, v); check("R4 both AND", v, 8'hC0);
        wr(2'd0, 8'h30);
        rd(2'd0, v); check("R4 none", v, 8'hFF);
        wr(2'd1, 8'h00); idle(1);
        rd(2'd1, v); check("R4 flags cleared", v, 8'hE0);
    endtask

    task automatic test_joy_edge();
        logic [7:0] v;
        pad_state = 8'hF7; idle(1);
        rd(2'd1, v); check("R5 no edge with none selected", v, 8'hE0);
        wr(2'd0, 8'h20);
        idle(1);
        rd(2'd1, v); check("R5 select-caused fall", v, 8'hF0);
        wr(2'd1, 8'h00); idle(1);
        pad_state = 8'hF3; idle(2);
        rd(2'd1, v); check("R5 state-caused fall", v, 8'hF0);
        wr(2'd1, 8'h00); idle(1);
        pad_state = 8'hFF; idle(2);
        rd(2'd1, v); check("R5 rise sets nothing", v, 8'hE0);
    endtask

    task automatic test_flag_write();
        logic [7:0] v;
        wr(2'd1, 8'h0B); idle(1);
        rd(2'd1, v); check("R6 write 0B", v, 8'hEB);
        wr(2'd1, 8'h00); idle(1);
        rd(2'd1, v); check("R6 write 00", v, 8'hE0);
    endtask

    task automatic test_delay();
        logic [7:0] v;
        wr(2'd1, 8'h03);
        rd(2'd1, v); check("R8 previous value", v, 8'hE0);
        idle(1);
        rd(2'd1, v); check("R8 new value", v, 8'hE3);
        wr(2'd1, 8'h00); idle(1);
    endtask

    task automatic test_hw();
        logic [7:0] v;
        @(negedge clk); hw_req = 5'h04;
        @(negedge clk); hw_req = 5'h00;
        idle(1);
        rd(2'd1, v); check("R7 timer pulse", v, 8'hE4);
        wr(2'd1, 8'h00); idle(1);
        @(negedge clk);
        cpu_addr = 2'd1; cpu_wdata = 8'h01; cpu_we = 1'b1; hw_req = 5'h08;
        @(negedge clk);
        cpu_we = 1'b0; hw_req = 5'h00;
        idle(1);
        rd(2'd1, v); check("R7 write and pulse same cycle", v, 8'hE9);
        wr(2'd1, 8'h00); idle(1);
    endtask

    task automatic test_irq();
        logic [7:0] v;
        wr(2'd2, 8'h04);
        check("R9 no flags", {7'd0, cpu_irq}, 8'h00);
        @(negedge clk); hw_req = 5'h04;
        @(negedge clk); hw_req = 5'h00;
        check("R9 pulse raises line", {7'd0, cpu_irq}, 8'h01);
        wr(2'd1, 8'h00);
        check("R9 flag clear drops line", {7'd0, cpu_irq}, 8'h00);
        wr(2'd1, 8'h1F);
        wr(2'd2, 8'hE0);
        check("R9 upper enables ignored", {7'd0, cpu_irq}, 8'h00);
        wr(2'd2, 8'h10);
        check("R9 enable raises line", {7'd0, cpu_irq}, 8'h01);
        wr(2'd2, 8'h00);
        check("R9 enable clear drops line", {7'd0, cpu_irq}, 8'h00);
        wr(2'd1, 8'h00);
    endtask

    task automatic test_enable_rw();
        logic [7:0] v;
        wr(2'd2, 8'hA5);
        rd(2'd2, v); check("R10 enable readback", v, 8'hA5);
        wr(2'd3, 8'h00);
        rd(2'd3, v); check("R10 unused index", v, 8'hFF);
        rd(2'd2, v); check("R10 enable untouched", v, 8'hA5);
        rd(2'd0, v); check("R10 pad untouched", v, 8'hEF);
        wr(2'd2, 8'h00);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        test_reset();
        rst_n = 1'b1;
        test_pad_write();
        test_groups();
        test_joy_edge();
        test_flag_write();
        test_delay();
        test_hw();
        test_irq();
        test_enable_rw();
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            checks++;
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule